// File: doc/BRIEF.md
# Strap-Selected Program Memory Decoder

This block sits between a DSP core's program memory port and the memories behind it. Each request carries a 14-bit word address. The block steers it to one of three places: on-chip RAM, on-chip ROM, or the external memory bus. Where the on-chip RAM and ROM appear in the address space depends on two strap inputs: a map-high strap and a boot strap. A ROM-enable bit can also hand the ROM window back to external memory.

On-chip targets answer at once. External accesses are held for a programmable number of wait states before ready is raised. The ROM-enable bit and the 3-bit wait count live in a small configuration register. A single write strobe loads both. On reset, the wait count becomes its maximum. ROM enable is set on reset only when both straps are high. A separate output flags requests that land in the interrupt vector area at the bottom of the map.

The core raises `req` and holds `addr` until it sees `rdy`. It drops `req` on the cycle after that.

Top module: `pm_decode_top`

## Requirements
- R1: With both straps low, addresses 0x0000–0x07FF select on-chip RAM, 0x0800–0x0FFF select ROM (or external, per R4) and 0x1000–0x3FFF select external memory.
- R2: With map_hi=1 and boot_sel=0, addresses 0x3800–0x3FFF select on-chip RAM and every other address selects external memory; ROM is never selected, whatever the ROM-enable bit holds.
- R3: With both straps high, 0x0000–0x07FF select RAM, 0x0800–0x0FFF select ROM (or external, per R4) and addresses from 0x1000 up select external memory. The combination map_hi=0, boot_sel=1 decodes like R1.
- R4: Apart from the R2 mode, the 0x0800–0x0FFF window selects ROM only while the ROM-enable bit is 1. While that bit is 0, the window selects external memory.
- R5: A synchronous reset sets the ROM-enable bit to 1 when both straps are high, and to 0 otherwise. A cycle with `cfg_we`=1 loads `cfg_rom_en` into it and `cfg_wait` into the wait count.
- R6: `sel_ram`, `sel_rom` and `ext_cs` are never more than one high at a time, and all are low while `req` is low.
- R7: A request to RAM or ROM sees `rdy` high in the same cycle as the request.
- R8: An external request accepted in cycle 0 sees `rdy` first in cycle N, where N is the wait count (0–7) at acceptance.
- R9: After reset the wait count is 7.
- R10: `vec_hit` is high exactly while `req` is high and `addr` is below 0x0060.
- R11: While an external access is waiting, the region selects hold their values from the accepting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, held until rdy |
| addr | input | 14 | Program word address |
| map_hi | input | 1 | Map-high strap |
| boot_sel | input | 1 | Boot strap |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_rom_en | input | 1 | ROM-enable value to load |
| cfg_wait | input | 3 | Wait count to load |
| sel_ram | output | 1 | On-chip RAM select |
| sel_rom | output | 1 | On-chip ROM select |
| ext_cs | output | 1 | External memory strobe |
| rdy | output | 1 | Access complete |
| vec_hit | output | 1 | Request falls in interrupt vector area |

## Verification
On every cycle, the assertions check four things: the selects are exclusive and quiet without a request, on-chip hits are ready at once, the map-high mode never picks ROM, and the vector flag is consistent. They also check that the selects stay frozen during a wait. The exact number of wait cycles and the full address-to-region map across all strap modes and ROM-enable settings can only be shown by the bench. The same holds for the reset values of the configuration register. The bench compares each access against a reference model, both in random scenarios and at the window edges.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_RAM  = 2'd1,
    RG_ROM  = 2'd2,
    RG_EXT  = 2'd3
  } region_t;
endpackage

// File: rtl/pm_region_dec.sv
module pm_region_dec
  import pm_pkg::*;
#(
  parameter int AW       = 14,
  parameter int BLK_LOG2 = 11
) (
  input  logic [AW-1:0] addr,
  input  logic          map_hi,
  input  logic          boot_sel,
  input  logic          rom_on,
  output region_t       rg
);
  localparam int HI_BASE_I = (1 << AW) - (1 << BLK_LOG2);
  localparam logic [AW-1:0] HI_BASE = AW'(HI_BASE_I);
  localparam int UW = AW - BLK_LOG2;

  logic in_low, in_romwin, in_hi;

  assign in_low    = (addr[AW-1:BLK_LOG2] == '0);
  assign in_romwin = (addr[AW-1:BLK_LOG2] == UW'(1));
  assign in_hi     = (addr >= HI_BASE);

  always_comb begin
    if (map_hi && !boot_sel) begin
      rg = in_hi ? RG_RAM : RG_EXT;
    end else if (in_low) begin
      rg = RG_RAM;
    end else if (in_romwin && rom_on) begin
      rg = RG_ROM;
    end else begin
      rg = RG_EXT;
    end
  end
endmodule

// File: rtl/pm_cfg_reg.sv
module pm_cfg_reg #(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_mode,
  input  logic          we,
  input  logic          rom_in,
  input  logic [WW-1:0] wait_in,
  output logic          rom_en,
  output logic [WW-1:0] pwait
);
  localparam logic [WW-1:0] PWAIT_RST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_en <= boot_mode;
      pwait  <= PWAIT_RST;
    end else if (we) begin
      rom_en <= rom_in;
      pwait  <= wait_in;
    end
  end
endmodule

// File: rtl/pm_wait_ctr.sv
module pm_wait_ctr #(
  parameter int WW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          hold,
  input  logic [WW-1:0] load,
  output logic          busy,
  output logic          zero_now
);
  logic [WW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start && load != '0) begin
        busy <= 1'b1;
        cnt  <= load - WW'(1);
      end
    end else if (!hold || cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - WW'(1);
    end
  end

  assign zero_now = busy ? (cnt == '0) : (load == '0);
endmodule

// File: rtl/pm_decode_top.sv
module pm_decode_top
  import pm_pkg::*;
#(
  parameter int AW        = 14,
  parameter int BLK_LOG2  = 11,
  parameter int WW        = 3,
  parameter int VEC_LIMIT = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          map_hi,
  input  logic          boot_sel,
  input  logic          cfg_we,
  input  logic          cfg_rom_en,
  input  logic [WW-1:0] cfg_wait,
  output logic          sel_ram,
  output logic          sel_rom,
  output logic          ext_cs,
  output logic          rdy,
  output logic          vec_hit
);
  localparam logic [AW-1:0] VEC_END = AW'(VEC_LIMIT);

  logic          rom_en;
  logic [WW-1:0] pwait;
  region_t       rg_live, rg_held, rg_eff;
  logic          busy, zero_now;

  pm_cfg_reg #(.WW(WW)) u_cfg (
    .clk(clk), .rst(rst), .boot_mode(map_hi & boot_sel),
    .we(cfg_we), .rom_in(cfg_rom_en), .wait_in(cfg_wait),
    .rom_en(rom_en), .pwait(pwait)
  );

  pm_region_dec #(.AW(AW), .BLK_LOG2(BLK_LOG2)) u_dec (
    .addr(addr), .map_hi(map_hi), .boot_sel(boot_sel),
    .rom_on(rom_en), .rg(rg_live)
  );

  pm_wait_ctr #(.WW(WW)) u_wait (
    .clk(clk), .rst(rst),
    .start(req && rg_live == RG_EXT), .hold(req),
    .load(pwait), .busy(busy), .zero_now(zero_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_held <= RG_NONE;
    end else if (!busy) begin
      rg_held <= rg_live;
    end
  end

  assign rg_eff  = busy ? rg_held : rg_live;
  assign sel_ram = req && rg_eff == RG_RAM;
  assign sel_rom = req && rg_eff == RG_ROM;
  assign ext_cs  = req && rg_eff == RG_EXT;
  assign rdy     = sel_ram || sel_rom || (ext_cs && zero_now);
  assign vec_hit = req && (addr < VEC_END);
endmodule

// File: rtl/pm_decode_chk.sv
module pm_decode_chk #(
  parameter int AW        = 14,
  parameter int VEC_LIMIT = 96
) (
  input logic          clk,
  input logic          rst,
  input logic          req,
  input logic [AW-1:0] addr,
  input logic          map_hi,
  input logic          boot_sel,
  input logic          sel_ram,
  input logic          sel_rom,
  input logic          ext_cs,
  input logic          rdy,
  input logic          vec_hit,
  input logic          busy
);
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_ram, sel_rom, ext_cs}));

  assert_sel_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !req |-> !(sel_ram || sel_rom || ext_cs || rdy));

  assert_int_ready_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_ram || sel_rom) |-> rdy);

  assert_hi_no_rom_R2: assert property (@(posedge clk) disable iff (rst)
    (req && map_hi && !boot_sel) |-> !sel_rom);

  assert_vec_range_R10: assert property (@(posedge clk) disable iff (rst)
    vec_hit |-> (req && addr < AW'(VEC_LIMIT)));

  assert_hold_sel_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && req) |-> $stable({sel_ram, sel_rom, ext_cs}));
endmodule

bind pm_decode_top pm_decode_chk #(.AW(AW), .VEC_LIMIT(VEC_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .req(req), .addr(addr), .map_hi(map_hi),
  .boot_sel(boot_sel), .sel_ram(sel_ram), .sel_rom(sel_rom),
  .ext_cs(ext_cs), .rdy(rdy), .vec_hit(vec_hit), .busy(busy)
);

// File: tb/pm_decode_top_tb.sv
`timescale 1ns/1ps
module pm_decode_top_tb;
  logic clk = 1'b0;
  logic rst, req, map_hi, boot_sel, cfg_we, cfg_rom_en;
  logic [13:0] addr;
  logic [2:0]  cfg_wait;
  logic sel_ram, sel_rom, ext_cs, rdy, vec_hit;

  int total = 0;
  int bad = 0;
  int m_wait;
  bit m_rom;

  always #10 clk = ~clk;

  pm_decode_top u_dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr), .map_hi(map_hi),
    .boot_sel(boot_sel), .cfg_we(cfg_we), .cfg_rom_en(cfg_rom_en),
    .cfg_wait(cfg_wait), .sel_ram(sel_ram), .sel_rom(sel_rom),
    .ext_cs(ext_cs), .rdy(rdy), .vec_hit(vec_hit)
  );

  // 1 = RAM, 2 = ROM, 3 = external
  function automatic int exp_region(int a, bit mh, bit bs, bit ro);
    if (mh && !bs) return (a >= 16'h3800) ? 1 : 3;
    if (a < 16'h0800) return 1;
    if (a < 16'h1000 && ro) return 2;
    return 3;
  endfunction

  function automatic string mode_tag(int a, bit mh, bit bs);
    if (mh && !bs) return "R2";
    if (a >= 16'h0800 && a < 16'h1000) return "R4";
    if (mh && bs) return "R3";
    return "R1";
  endfunction

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(bit mh, bit bs);
    @(negedge clk);
    map_hi = mh; boot_sel = bs; rst = 1'b1; req = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_wait = 7;
    m_rom = mh & bs;
  endtask

  task automatic cfg_write(bit ro, int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rom_en = ro; cfg_wait = 3'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    m_rom = ro;
    m_wait = w;
  endtask

  task automatic access(int a, string wtag);
    int er, got, k;
    string tg;
    @(negedge clk);
    req = 1'b1; addr = 14'(a);
    #1;
    er = exp_region(a, map_hi, boot_sel, m_rom);
    tg = mode_tag(a, map_hi, boot_sel);
    got = sel_ram ? 1 : sel_rom ? 2 : ext_cs ? 3 : 0;
    chk({tg, " region"}, got, er);
    chk("R10 vec_hit", int'(vec_hit), int'(a < 96));
    k = 0;
    while (!rdy && k < 20) begin
      @(negedge clk); #1;
      got = sel_ram ? 1 : sel_rom ? 2 : ext_cs ? 3 : 0;
      if (got != er) chk("R11 held region", got, er);
      k++;
    end
    if (er == 3) chk({wtag, " wait states"}, k, m_wait);
    else chk("R7 internal ready", k, 0);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    rst = 1'b1; req = 1'b0; addr = '0; map_hi = 1'b0; boot_sel = 1'b0;
    cfg_we = 1'b0; cfg_rom_en = 1'b0; cfg_wait = '0;

    // reset in boot mode: ROM enabled, wait 7
    do_reset(1'b1, 1'b1);
    #1;
    chk("R6 idle selects", int'({sel_ram, sel_rom, ext_cs, rdy}), 0);
    access(16'h0900, "R5");   // ROM on after reset in boot mode
    access(16'h1000, "R9");   // reset wait count 7
    access(16'h0000, "R3");
    access(16'h005F, "R3");
    access(16'h0060, "R3");
    access(16'h07FF, "R3");
    access(16'h0800, "R3");
    access(16'h0FFF, "R3");
    access(16'h3FFF, "R3");

    // reset in plain mode: ROM off
    do_reset(1'b0, 1'b0);
    access(16'h0800, "R5");
    access(16'h2000, "R9");
    cfg_write(1'b1, 0);
    access(16'h0800, "R8");
    access(16'h0FFF, "R8");
    access(16'h1000, "R8");
    cfg_write(1'b0, 3);
    access(16'h0A00, "R8");

    // map-high mode ignores ROM enable
    map_hi = 1'b1; boot_sel = 1'b0;
    cfg_write(1'b1, 2);
    access(16'h0800, "R8");
    access(16'h37FF, "R8");
    access(16'h3800, "R8");
    access(16'h0000, "R8");

    // odd strap combination decodes like both-low
    map_hi = 1'b0; boot_sel = 1'b1;
    access(16'h0400, "R8");
    access(16'h0C00, "R8");

    // random mix
    for (int i = 0; i < 300; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) cfg_write(1'($urandom_range(0, 1)), int'($urandom_range(0, 7)));
      if (sel == 1) begin
        map_hi = 1'($urandom_range(0, 1));
        boot_sel = 1'($urandom_range(0, 1));
      end
      access(int'($urandom_range(0, 16'h3FFF)), "R8");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule